// File: doc/BRIEF.md
# Low-Run Start-of-Frame Detector

This block watches one already-sliced serial receive line and announces the start of a frame. A frame is recognised when the line stays low, without a single high sample, for a fixed number of bit periods. The default is eight. The line is first retimed by a short flop chain. It is then sampled on an oversampling tick that a prescaler produces, sixteen ticks per bit period by default. Any high sample empties the low-run count, so the detector keeps searching through the random toggling seen between frames and only reacts to a long quiet run.

The bit period is set by a two-bit rate code. That code is captured while reset is held and kept until the next reset. On a match the block raises `start_o` for exactly one bit period. It then raises `arm_o` to release a downstream bit-clock extractor. While either output is high, new low runs are ignored. The block returns to searching, with an empty count, once the extractor reports idle. Payload decoding and end-of-frame detection are left to other logic.

Top module: `lowrun_sod_detect`

## Requirements
- R1: The rate code `rate_sel_i` selects the oversample tick period as `BASE_DIV` clocks times 8, 4, 2 or 1 for codes 2'b00, 2'b01, 2'b10 and 2'b11 (bit 1 is the high select), which gives 2400, 4800, 9600 and 19200 bit/s at the default setting. One bit period is `OVS` ticks.
- R2: `rate_sel_i` is captured on every clock edge where `rst_ni` is low, and only then. Changing it after reset has no effect on timing.
- R3: In the searching state, `start_o` rises after the retimed line has been low on `BITS_REQ*OVS` consecutive ticks. A low run of `BITS_REQ-1` bit periods gives no start.
- R4: Any clock cycle with the retimed line high clears the low-run count. This includes a single-cycle high between two low stretches.
- R5: `start_o` is one contiguous pulse lasting exactly one bit period (`OVS` ticks, i.e. `OVS*` tick-period clock cycles). Each accepted run produces only one pulse.
- R6: `arm_o` goes high in the cycle after `start_o` falls. It stays high until `ext_idle_i` is sampled high, after which both outputs are low and searching resumes with an empty count.
- R7: While `start_o` or `arm_o` is high, low runs of any length produce no new start.
- R8: While and directly after reset, `start_o` and `arm_o` are low.
- R9: Noise whose low stretches are all shorter than `BITS_REQ` bit periods never produces a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Synchronous reset, active low; also the rate capture window |
| rate_sel_i | input | 2 | Rate code, captured only during reset |
| rx_line_i | input | 1 | Sliced serial receive line, asynchronous |
| ext_idle_i | input | 1 | Downstream extractor idle; ends the armed state |
| start_o | output | 1 | Start-of-frame pulse, one bit period long |
| arm_o | output | 1 | Enable for the downstream bit-clock extractor |

## Verification
Two functions can meet in the same cycle: completing a qualifying low run, and the release of the armed state by `ext_idle_i`. The bench holds the line low through a whole armed interval and raises `ext_idle_i` while the line is still low. It then checks that the run which straddled the release gives no start, because the count restarts at release. After that, a fresh full-length run is still accepted. The bench also checks that a run just long enough to trigger at the first tick after a single-cycle high never fires, because the high cycle clears the count before that tick is counted.

// File: rtl/lowrun_sod_pkg.sv
package lowrun_sod_pkg;

   typedef enum logic [1:0] {
      RATE_X8 = 2'b00,
      RATE_X4 = 2'b01,
      RATE_X2 = 2'b10,
      RATE_X1 = 2'b11
   } rate_code_e;

   typedef enum logic [1:0] {
      ST_SEARCH = 2'b00,
      ST_PULSE  = 2'b01,
      ST_ARMED  = 2'b10
   } sod_state_e;

   localparam int unsigned RATE_COUNT    = 4;
   localparam int unsigned RATE_MAX_MULT = 8;

   function automatic int unsigned rate_mult(input int unsigned code);
      return RATE_MAX_MULT >> code;
   endfunction

endpackage

// File: rtl/lowrun_sod_sync.sv
module lowrun_sod_sync #(
   parameter int unsigned STAGES   = 2,
   parameter logic        RST_LEVEL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("lowrun_sod_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) chain_q <= {STAGES{RST_LEVEL}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lowrun_sod_prescale.sv
module lowrun_sod_prescale
   import lowrun_sod_pkg::*;
#(
   parameter int unsigned BASE_DIV = 163,
   localparam int unsigned DIV_W   = $clog2(BASE_DIV*RATE_MAX_MULT + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [1:0]       rate_sel_i,
   output rate_code_e       rate_q_o,
   output logic [DIV_W-1:0] div_o,
   output logic             tick_o
);
   logic [DIV_W-1:0] div_tab [RATE_COUNT];
   logic [DIV_W-1:0] cnt_q;
   rate_code_e       rate_q;

   genvar g;
   generate
      for (g = 0; g < RATE_COUNT; g++) begin : g_tab
         localparam int unsigned MULT = rate_mult(g);
         assign div_tab[g] = DIV_W'(BASE_DIV * MULT);
      end
   endgenerate

   // Rate code latched only while reset is asserted.
   always_ff @(posedge clk_i) begin
      if (!rst_ni) rate_q <= rate_code_e'(rate_sel_i);
   end

   assign div_o  = div_tab[rate_q];
   assign tick_o = (cnt_q == div_o - DIV_W'(1));

   always_ff @(posedge clk_i) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + DIV_W'(1);
   end

   assign rate_q_o = rate_q;
endmodule

// File: rtl/lowrun_sod_runcnt.sv
module lowrun_sod_runcnt #(
   parameter int unsigned RUN_TICKS = 128,
   localparam int unsigned RUN_W    = $clog2(RUN_TICKS + 1)
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic tick_i,
   input  logic line_i,
   output logic hit_o
);
   logic [RUN_W-1:0] run_q;

   generate
      if (RUN_TICKS < 2) begin : g_bad
         $error("lowrun_sod_runcnt: RUN_TICKS must be at least 2");
      end
   endgenerate

   // Final low tick of the run while searching.
   assign hit_o = en_i && tick_i && !line_i && (run_q == RUN_W'(RUN_TICKS - 1));

   always_ff @(posedge clk_i) begin
      if (!rst_ni || !en_i || line_i)
         run_q <= '0;
      else if (tick_i && run_q != RUN_W'(RUN_TICKS))
         run_q <= run_q + RUN_W'(1);
   end
endmodule

// File: rtl/lowrun_sod_fsm.sv
module lowrun_sod_fsm
   import lowrun_sod_pkg::*;
#(
   parameter int unsigned OVS   = 16,
   localparam int unsigned OVS_W = (OVS > 1) ? $clog2(OVS) : 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic hit_i,
   input  logic tick_i,
   input  logic ext_idle_i,
   output logic search_o,
   output logic start_o,
   output logic arm_o
);
   sod_state_e       state_q, state_d;
   logic [OVS_W-1:0] ph_q, ph_d;
   logic             last_tick;

   assign last_tick = tick_i && (ph_q == OVS_W'(OVS - 1));

   always_comb begin
      state_d = state_q;
      ph_d    = ph_q;
      unique case (state_q)
         ST_SEARCH: begin
            ph_d = '0;
            if (hit_i) state_d = ST_PULSE;
         end
         ST_PULSE: begin
            if (last_tick) begin
               state_d = ST_ARMED;
               ph_d    = '0;
            end else if (tick_i) begin
               ph_d = ph_q + OVS_W'(1);
            end
         end
         ST_ARMED: begin
            if (ext_idle_i) state_d = ST_SEARCH;
         end
         default: state_d = ST_SEARCH;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= ST_SEARCH;
         ph_q    <= '0;
      end else begin
         state_q <= state_d;
         ph_q    <= ph_d;
      end
   end

   assign search_o = (state_q == ST_SEARCH);
   assign start_o  = (state_q == ST_PULSE);
   assign arm_o    = (state_q == ST_ARMED);
endmodule

// File: rtl/lowrun_sod_detect.sv
module lowrun_sod_detect
   import lowrun_sod_pkg::*;
#(
   parameter int unsigned BASE_DIV    = 163,
   parameter int unsigned OVS         = 16,
   parameter int unsigned BITS_REQ    = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned DIV_W      = $clog2(BASE_DIV*RATE_MAX_MULT + 1),
   localparam int unsigned RUN_TICKS  = BITS_REQ * OVS
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [1:0] rate_sel_i,
   input  logic       rx_line_i,
   input  logic       ext_idle_i,
   output logic       start_o,
   output logic       arm_o
);
   generate
      if (BASE_DIV < 1) begin : g_bad_div
         $error("lowrun_sod_detect: BASE_DIV must be at least 1");
      end
      if (OVS < 2) begin : g_bad_ovs
         $error("lowrun_sod_detect: OVS must be at least 2");
      end
      if (BITS_REQ < 1) begin : g_bad_bits
         $error("lowrun_sod_detect: BITS_REQ must be at least 1");
      end
   endgenerate

   logic             line_s;
   logic             tick;
   logic             hit;
   logic             searching;
   rate_code_e       rate_lat;
   logic [DIV_W-1:0] tick_div;

   lowrun_sod_sync #(
      .STAGES   (SYNC_STAGES),
      .RST_LEVEL(1'b1)
   ) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (rx_line_i),
      .q_o   (line_s)
   );

   lowrun_sod_prescale #(
      .BASE_DIV(BASE_DIV)
   ) u_presc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rate_sel_i(rate_sel_i),
      .rate_q_o  (rate_lat),
      .div_o     (tick_div),
      .tick_o    (tick)
   );

   lowrun_sod_runcnt #(
      .RUN_TICKS(RUN_TICKS)
   ) u_run (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (searching),
      .tick_i(tick),
      .line_i(line_s),
      .hit_o (hit)
   );

   lowrun_sod_fsm #(
      .OVS(OVS)
   ) u_fsm (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hit_i     (hit),
      .tick_i    (tick),
      .ext_idle_i(ext_idle_i),
      .search_o  (searching),
      .start_o   (start_o),
      .arm_o     (arm_o)
   );
endmodule

// File: rtl/lowrun_sod_checker.sv
module lowrun_sod_checker #(
   parameter int unsigned OVS   = 16,
   parameter int unsigned DIV_W = 11
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [1:0]       rate_sel_i,
   input logic [1:0]       rate_lat,
   input logic [DIV_W-1:0] tick_div,
   input logic             line_s,
   input logic             ext_idle_i,
   input logic             start_o,
   input logic             arm_o
);
   localparam int unsigned WW = DIV_W + $clog2(OVS) + 2;
   logic [WW-1:0] width_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni || !start_o) width_q <= '0;
      else                     width_q <= width_q + WW'(1);
   end

   p_reset_quiet_r8: assert property (@(posedge clk_i)
      !rst_ni |=> (!start_o && !arm_o));

   p_rate_capture_r2: assert property (@(posedge clk_i)
      !rst_ni |=> (rate_lat == $past(rate_sel_i)));

   p_rate_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> $stable(rate_lat));

   p_start_on_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(start_o) |-> !$past(line_s));

   p_no_retrigger_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(start_o) |-> !$past(arm_o));

   p_exclusive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(start_o && arm_o));

   p_pulse_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_o |-> (width_q < WW'(tick_div) * WW'(OVS)));

   p_arm_follows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(start_o) |-> arm_o);

   p_arm_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (arm_o && !ext_idle_i) |=> arm_o);

   p_arm_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (arm_o && ext_idle_i) |=> (!arm_o && !start_o));
endmodule

bind lowrun_sod_detect lowrun_sod_checker #(
   .OVS  (OVS),
   .DIV_W(DIV_W)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .rate_sel_i(rate_sel_i),
   .rate_lat  (rate_lat),
   .tick_div  (tick_div),
   .line_s    (line_s),
   .ext_idle_i(ext_idle_i),
   .start_o   (start_o),
   .arm_o     (arm_o)
);

// File: tb/lowrun_sod_detect_bench.sv
`timescale 1ns/1ps
module lowrun_sod_detect_bench;
   localparam int unsigned BASE = 2;
   localparam int unsigned OVS  = 16;
   localparam int unsigned BITS = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] rate_sel = 2'b00;
   logic       line = 1'b1;
   logic       idle = 1'b0;
   logic       start_o, arm_o;

   int runs = 0, fails = 0;
   int starts = 0, width_cur = 0, last_w = 0;
   logic prev_start = 1'b0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   lowrun_sod_detect #(.BASE_DIV(BASE), .OVS(OVS), .BITS_REQ(BITS)) u_lowrun_sod_detect (
      .clk_i(clk), .rst_ni(rst_n), .rate_sel_i(rate_sel), .rx_line_i(line),
      .ext_idle_i(idle), .start_o(start_o), .arm_o(arm_o));

   always @(negedge clk) begin
      if (start_o && !prev_start) starts++;
      if (start_o) width_cur++;
      if (!start_o && prev_start) begin
         last_w = width_cur;
         width_cur = 0;
      end
      prev_start = start_o;
   end

   function automatic int bitp(input int r);
      return BASE * (8 >> r) * OVS;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      runs++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input int r);
      @(negedge clk);
      rst_n = 1'b0; rate_sel = 2'(r); line = 1'b1; idle = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic low_run(input int n);
      line = 1'b0;
      repeat (n) @(negedge clk);
      line = 1'b1;
   endtask

   task automatic release_arm();
      idle = 1'b1;
      @(negedge clk);
      idle = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   // R8: outputs quiet through and after reset
   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(!start_o && !arm_o, "R8 quiet in reset", {start_o, arm_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!start_o && !arm_o, "R8 quiet after reset", {start_o, arm_o}, 0);
   endtask

   // R3: seven-bit run must not trigger
   task automatic t_seven(input int r);
      int s0 = starts;
      low_run((BITS - 1) * bitp(r));
      repeat (2 * bitp(r)) @(negedge clk);
      chk(starts == s0 && !arm_o, "R3 short run", starts - s0, 0);
   endtask

   // R3 R1 R5 R6: exact eight-bit run triggers once, width is one bit period
   task automatic t_eight(input int r);
      int s0 = starts;
      low_run(BITS * bitp(r));
      repeat (bitp(r) + 10) @(negedge clk);
      chk(starts == s0 + 1, "R3 exact run start", starts - s0, 1);
      chk(last_w == bitp(r), "R1 R5 pulse width", last_w, bitp(r));
      chk(arm_o == 1'b1, "R6 arm after start", arm_o, 1);
      release_arm();
      chk(!arm_o && !start_o, "R6 arm released", arm_o, 0);
   endtask

   // R9: noise with short low stretches
   task automatic t_noise(input int r);
      int s0 = starts;
      for (int k = 0; k < 12; k++) begin
         line = ~line;
         repeat (1 + ($urandom % (5 * bitp(r)))) @(negedge clk);
      end
      line = 1'b1;
      repeat (bitp(r)) @(negedge clk);
      chk(starts == s0, "R9 noise", starts - s0, 0);
   endtask

   // R4: single high cycle splits a run
   task automatic t_glitch(input int r);
      int s0 = starts;
      line = 1'b0;
      repeat (5 * bitp(r)) @(negedge clk);
      line = 1'b1;
      @(negedge clk);
      low_run(5 * bitp(r));
      repeat (2 * bitp(r)) @(negedge clk);
      chk(starts == s0, "R4 high sample clears", starts - s0, 0);
   endtask

   // R4 edge: run one tick short of full after the glitch
   task automatic t_glitch_tight(input int r);
      int s0 = starts;
      line = 1'b0;
      repeat (bitp(r)) @(negedge clk);
      line = 1'b1;
      @(negedge clk);
      low_run(BITS * bitp(r) - BASE * (8 >> r));
      repeat (2 * bitp(r)) @(negedge clk);
      chk(starts == s0, "R4 tight split", starts - s0, 0);
   endtask

   // R7 R6: blocked while armed, count cleared at release
   task automatic t_blocked(input int r);
      int s0;
      low_run(BITS * bitp(r));
      repeat (bitp(r) + 10) @(negedge clk);
      s0 = starts;
      low_run((BITS + 1) * bitp(r));
      repeat (bitp(r)) @(negedge clk);
      chk(starts == s0 && arm_o, "R7 blocked while armed", starts - s0, 0);
      line = 1'b0;
      repeat (4 * bitp(r)) @(negedge clk);
      idle = 1'b1;
      @(negedge clk);
      idle = 1'b0;
      repeat ((BITS - 1) * bitp(r)) @(negedge clk);
      line = 1'b1;
      repeat (2 * bitp(r)) @(negedge clk);
      chk(starts == s0 && !arm_o, "R6 count cleared at release", starts - s0, 0);
      low_run(BITS * bitp(r));
      repeat (bitp(r) + 10) @(negedge clk);
      chk(starts == s0 + 1, "R6 search resumed", starts - s0, 1);
      release_arm();
   endtask

   // R2: rate pins ignored after reset
   task automatic t_rate_latch();
      do_reset(3);
      rate_sel = 2'b00;
      repeat (5) @(negedge clk);
      low_run(BITS * bitp(3));
      repeat (bitp(3) + 10) @(negedge clk);
      chk(last_w == bitp(3), "R2 rate kept after reset", last_w, bitp(3));
      release_arm();
   endtask

   initial begin
      t_reset();
      for (int r = 0; r < 4; r++) begin
         do_reset(r);
         t_seven(r);
         t_eight(r);
         t_noise(r);
         t_glitch(r);
         t_glitch_tight(r);
         t_blocked(r);
      end
      t_rate_latch();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", runs, fails);
      end
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         runs++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", runs, fails);
      end
      $finish;
   end
endmodule